// File: doc/BRIEF.md
# Dual-Buffer Transmit Frame Controller

This block is the transmit half of a simple Ethernet MAC. Software fills two packet buffers, called ping and pong, through a 32-bit register bus. Each buffer has its own byte-count register and its own status word. Setting the busy bit of a status word hands that buffer to the hardware. The hardware then streams the stored bytes on a byte-wide valid/ready output, marks the first and last byte, and clears busy when the frame ends. If the busy and program bits are written together, the hardware loads the first six bytes of the buffer into a 48-bit station address output and sends no frame. Preamble, CRC, PHY signalling and collisions are handled by other logic downstream.

The bus is word addressed. Address bit 9 selects the buffer: 0 is ping and 1 is pong, which puts pong 0x800 bytes above ping. Inside each 512-word window, the frame data occupies words 0x000 to 0x1FC. The byte count is at word 0x1FD (byte offset 0x7F4) and the status word is at word 0x1FF (byte offset 0x7FC). Writes to word 0x1FE are ignored.

A reads of a register is combinational. Frame data is stored in a dual-buffer RAM that has a single registered read port, and the engine reads from it one word at a time. The engine is a five-state machine:
- IDLE picks a busy buffer and, when both are busy, takes the one that was started first.
- FETCH reads one data word.
- SEND presents the bytes of that word, most significant byte first.
- COPY shifts bytes into the station address.
- DONE clears the status bits and raises the interrupt pulse.

The transitions are:
- IDLE to FETCH when a buffer is busy with a non-zero length or with the program bit set.
- IDLE to DONE when a buffer is busy with a zero length.
- FETCH to SEND for a transmit, or FETCH to COPY for a program command.
- SEND or COPY to FETCH after the last byte of a word.
- SEND or COPY to DONE after the final byte.
- DONE to IDLE.
- Any state to IDLE on an abort, which is a status write with busy clear to the buffer being served.

Top module: `pingpong_txbuf`

## Requirements
- R1: After reset, tx_valid, tx_first, tx_last and tx_done_irq are 0, station_addr is 0, and the length and status registers of both buffers read 0.
- R2: bus_addr bit 9 selects the buffer. The length register at word 0x1FD reads back the low 16 bits written to it, with the upper bits 0. Writing one buffer's length leaves the other buffer's length unchanged.
- R3: Writing a status word with bit 0 (busy) set and bit 1 (program) clear sends exactly `length` bytes from that buffer. Each data word is sent in big-endian order, bits 31:24 first. After the frame, status bit 0 reads 0.
- R4: tx_first is high only with the first byte of a frame, and tx_last is high only with its final byte.
- R5: While tx_valid is high and tx_ready is low, tx_data, tx_first and tx_last hold their values. A byte is consumed only in a cycle where tx_valid and tx_ready are both high.
- R6: When both buffers are busy, they are sent in the order their busy bits were set. The later buffer reads busy while it waits.
- R7: A busy buffer with length 0 sends no byte, and its busy bit clears.
- R8: tx_done_irq pulses for one cycle when a transmit completes with status bit 3 (interrupt enable) set. It does not pulse when bit 3 is clear.
- R9: Writing bits 0 and 1 together loads the buffer's first six bytes into station_addr, with the first byte in bits 47:40. No byte is sent, and both bits then read 0.
- R10: Status bit 31 reads back as written. Writing 0x8000_0000 starts nothing.
- R11: Writing a status word with bit 0 clear to the buffer being sent stops the frame. tx_valid is low from the next cycle, and busy reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 10 | Word address; bit 9 selects pong |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for the length and status registers at bus_addr; other addresses read 0 |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Final byte of a frame |
| tx_done_irq | output | 1 | One-cycle transmit-done pulse |
| station_addr | output | 48 | Loaded station address |

## Verification
A wrong byte counter or word index shows up as a wrong tx_data value, a misplaced tx_last, or a missing or extra byte on the first affected handshake. The bench compares every accepted byte against a queue of expected bytes, built in start order, so such a fault is reported within one cycle. A wrong arbitration order shows as the first byte of the wrong buffer's frame at the start of the second frame. A status bit left set, or an abort that is lost, shows on the next status read as busy still reading 1, or as tx_valid still high one cycle after the write.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SEND,
        S_COPY,
        S_DONE
    } ptb_state_t;

    localparam int BIT_BUSY  = 0;
    localparam int BIT_PROG  = 1;
    localparam int BIT_IE    = 3;
    localparam int BIT_KEEP  = 31;
    localparam int STA_BYTES = 6;
endpackage

// File: rtl/ptb_mem.sv
module ptb_mem #(
    parameter int AW     = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/ptb_regs.sv
module ptb_regs
    import ptb_pkg::*;
#(
    parameter int AW     = 10,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  mem_we,
    output logic [1:0]            busy,
    output logic [1:0]            prog,
    output logic [1:0]            ie,
    output logic                  older,
    output logic [1:0][LEN_W-1:0] len,
    output logic [1:0]            clr_wr,
    input  logic [1:0]            done_clr
);
    localparam int WI_W = AW - 1;
    localparam logic [WI_W-1:0] LEN_IDX  = WI_W'((1 << WI_W) - 3);
    localparam logic [WI_W-1:0] STAT_IDX = WI_W'((1 << WI_W) - 1);

    logic            sel_buf;
    logic [WI_W-1:0] idx;
    logic            is_len, is_stat;
    logic [1:0]      keep;

    assign sel_buf = bus_addr[AW-1];
    assign idx     = bus_addr[WI_W-1:0];
    assign is_len  = bus_we && (idx == LEN_IDX);
    assign is_stat = bus_we && (idx == STAT_IDX);
    assign mem_we  = bus_we && (idx < LEN_IDX);

    always_comb begin
        for (int b = 0; b < 2; b++) begin
            clr_wr[b] = is_stat && (sel_buf == 1'(b)) && !bus_wdata[BIT_BUSY];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= '0;
            prog  <= '0;
            ie    <= '0;
            keep  <= '0;
            len   <= '0;
            older <= 1'b0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (is_stat && (sel_buf == 1'(b))) begin
                    busy[b] <= bus_wdata[BIT_BUSY];
                    prog[b] <= bus_wdata[BIT_PROG];
                    ie[b]   <= bus_wdata[BIT_IE];
                    keep[b] <= bus_wdata[BIT_KEEP];
                end else if (done_clr[b]) begin
                    busy[b] <= 1'b0;
                    prog[b] <= 1'b0;
                end
                if (is_len && (sel_buf == 1'(b))) begin
                    len[b] <= bus_wdata[LEN_W-1:0];
                end
            end
            if (is_stat && bus_wdata[BIT_BUSY] && !busy[sel_buf]) begin
                older <= busy[~sel_buf] ? ~sel_buf : sel_buf;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (idx == LEN_IDX) begin
            bus_rdata = {{(DATA_W-LEN_W){1'b0}}, len[sel_buf]};
        end else if (idx == STAT_IDX) begin
            bus_rdata[BIT_BUSY] = busy[sel_buf];
            bus_rdata[BIT_PROG] = prog[sel_buf];
            bus_rdata[BIT_IE]   = ie[sel_buf];
            bus_rdata[BIT_KEEP] = keep[sel_buf];
        end
    end
endmodule

// File: rtl/ptb_engine.sv
module ptb_engine
    import ptb_pkg::*;
#(
    parameter int WI_W   = 9,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             busy,
    input  logic [1:0]             prog,
    input  logic [1:0]             ie,
    input  logic                   older,
    input  logic [1:0][LEN_W-1:0]  len,
    input  logic [1:0]             clr_wr,
    output logic                   rd_en,
    output logic [WI_W:0]          rd_addr,
    input  logic [DATA_W-1:0]      rd_data,
    output logic [1:0]             done_clr,
    output logic [7:0]             tx_data,
    output logic                   tx_valid,
    output logic                   tx_first,
    output logic                   tx_last,
    input  logic                   tx_ready,
    output logic                   irq,
    output logic [8*STA_BYTES-1:0] station_addr
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    ptb_state_t        state_q, state_d;
    logic              cur_q, pmode_q, sel;
    logic [LEN_W-1:0]  cnt_q, len_q, cnt_nx;
    logic [LANE_W-1:0] lane;
    logic [DATA_W-1:0] shifted;
    logic [7:0]        cur_byte;
    logic              last_byte, step, abort;

    assign sel       = (busy == 2'b11) ? older : busy[1];
    assign cnt_nx    = cnt_q + 1'b1;
    assign last_byte = (cnt_nx == len_q);
    assign lane      = LANE_W'(LANES - 1) - cnt_q[LANE_W-1:0];
    assign shifted   = rd_data >> {lane, 3'b000};
    assign cur_byte  = shifted[7:0];
    assign step      = ((state_q == S_SEND) && tx_ready) || (state_q == S_COPY);
    assign abort     = (state_q != S_IDLE) && clr_wr[cur_q];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if ((|busy) && !clr_wr[sel]) begin
                    if (prog[sel])           state_d = S_FETCH;
                    else if (len[sel] == '0) state_d = S_DONE;
                    else                     state_d = S_FETCH;
                end
            end
            S_FETCH: state_d = pmode_q ? S_COPY : S_SEND;
            S_SEND, S_COPY: begin
                if (step) begin
                    if (last_byte)                    state_d = S_DONE;
                    else if (&cnt_q[LANE_W-1:0])      state_d = S_FETCH;
                end
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
        if (abort) state_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= 1'b0;
            pmode_q      <= 1'b0;
            cnt_q        <= '0;
            len_q        <= '0;
            station_addr <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    cur_q   <= sel;
                    cnt_q   <= '0;
                    pmode_q <= prog[sel];
                    len_q   <= prog[sel] ? LEN_W'(STA_BYTES) : len[sel];
                end
                S_SEND: if (step) cnt_q <= cnt_nx;
                S_COPY: begin
                    cnt_q        <= cnt_nx;
                    station_addr <= {station_addr[8*STA_BYTES-9:0], cur_byte};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_en    = (state_q == S_FETCH);
        rd_addr  = {cur_q, cnt_q[LANE_W +: WI_W]};
        tx_valid = (state_q == S_SEND);
        tx_data  = cur_byte;
        tx_first = tx_valid && (cnt_q == '0);
        tx_last  = tx_valid && last_byte;
        done_clr = (state_q == S_DONE) ? (2'b01 << cur_q) : 2'b00;
        irq      = (state_q == S_DONE) && !pmode_q && ie[cur_q];
    end
endmodule

// File: rtl/pingpong_txbuf.sv
module pingpong_txbuf
    import ptb_pkg::*;
#(
    parameter int WIN_WORDS = 512,
    parameter int LEN_W     = 16,
    parameter int DATA_W    = 32,
    localparam int AW       = $clog2(WIN_WORDS) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [7:0]             tx_data,
    output logic                   tx_valid,
    input  logic                   tx_ready,
    output logic                   tx_first,
    output logic                   tx_last,
    output logic                   tx_done_irq,
    output logic [8*STA_BYTES-1:0] station_addr
);
    logic                  mem_we, rd_en, older;
    logic [AW-1:0]         rd_addr;
    logic [DATA_W-1:0]     rd_data;
    logic [1:0]            busy, prog, ie, clr_wr, done_clr;
    logic [1:0][LEN_W-1:0] len;

    ptb_mem #(.AW(AW), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(bus_addr), .wdata(bus_wdata),
        .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
    );

    ptb_regs #(.AW(AW), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_we(mem_we),
        .busy(busy), .prog(prog), .ie(ie), .older(older), .len(len),
        .clr_wr(clr_wr), .done_clr(done_clr)
    );

    ptb_engine #(.WI_W(AW-1), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .busy(busy), .prog(prog), .ie(ie),
        .older(older), .len(len), .clr_wr(clr_wr), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .done_clr(done_clr),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first),
        .tx_last(tx_last), .tx_ready(tx_ready), .irq(tx_done_irq),
        .station_addr(station_addr)
    );
endmodule

// File: rtl/ptb_chk.sv
module ptb_chk #(
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [IDX_W-1:0] idx,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             tx_first,
    input logic             tx_last,
    input logic             irq,
    input logic [47:0]      station_addr
);
    logic stat_wr;
    assign stat_wr = bus_we && (&idx);

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !stat_wr) |=> (tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last))); // R5

    AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_first || tx_last) |-> tx_valid); // R4

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

    AST_IRQ_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !tx_valid); // R8

    AST_STATION_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(station_addr) |-> !$past(tx_valid)); // R9
endmodule

bind pingpong_txbuf ptb_chk #(.IDX_W(AW-1)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .idx(bus_addr[AW-2:0]),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_first(tx_first), .tx_last(tx_last), .irq(tx_done_irq),
    .station_addr(station_addr)
);

// File: tb/test_pingpong_txbuf.sv
`timescale 1ns/1ps
module test_pingpong_txbuf;
    logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, tx_ready = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_first, tx_last, tx_done_irq;
    logic [47:0] station_addr;

    localparam logic [9:0] LEN_OFS  = 10'h1FD;
    localparam logic [9:0] STAT_OFS = 10'h1FF;

    int   vectors = 0, miscompares = 0, irq_cnt = 0, cyc = 0;
    bit   bp = 1'b0, ready_lvl = 1'b1;
    logic [9:0] expq[$];
    logic [7:0] img [2][64];

    always #5 clk = ~clk;

    pingpong_txbuf i_pingpong_txbuf (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_first(tx_first),
        .tx_last(tx_last), .tx_done_irq(tx_done_irq), .station_addr(station_addr)
    );

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        tx_ready <= bp ? (cyc % 3 != 0) : ready_lvl;
    end

    // per-clock comparison against the expected byte queue
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (tx_done_irq) irq_cnt++;
            if (tx_valid && expq.size() == 0) begin
                check(1'b0, "R3 byte with nothing expected", {54'd0, tx_first, tx_last, tx_data}, 64'd0);
            end else if (tx_valid && tx_ready) begin
                logic [9:0] e;
                e = expq.pop_front();
                check({tx_first, tx_last, tx_data} == e, "R3/R4 byte",
                      {54'd0, tx_first, tx_last, tx_data}, {54'd0, e});
            end
        end
    end

    function automatic logic [9:0] base(int b);
        return (b == 1) ? 10'h200 : 10'h000;
    endfunction

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic fill(int b, int n, logic [7:0] seed);
        for (int i = 0; i < 64; i++) img[b][i] = seed + 8'(i * 37);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            wr(base(b) + 10'(w), {img[b][4*w], img[b][4*w+1], img[b][4*w+2], img[b][4*w+3]});
        end
    endtask

    task automatic start(int b, int n, bit ien);
        for (int i = 0; i < n; i++) expq.push_back({i == 0, i == n - 1, img[b][i]});
        wr(base(b) + LEN_OFS, 32'(n));
        wr(base(b) + STAT_OFS, ien ? 32'h9 : 32'h1);
    endtask

    task automatic wait_idle(int b, logic [31:0] mask, string tag);
        logic [31:0] s;
        int k;
        for (k = 0; k < 3000; k++) begin
            rd(base(b) + STAT_OFS, s);
            if ((s & mask) == 0) break;
        end
        check(k < 3000, tag, {32'd0, s}, 64'd0);
    endtask

    task automatic drain(string tag);
        for (int k = 0; k < 2000 && expq.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(expq.size() == 0, tag, 64'(expq.size()), 64'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] s;
        int irq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1 reset state
        check(!tx_valid && !tx_first && !tx_last, "R1 stream idle", {61'd0, tx_valid, tx_first, tx_last}, 64'd0);
        check(!tx_done_irq, "R1 irq low", 64'(tx_done_irq), 64'd0);
        check(station_addr == 48'd0, "R1 station zero", 64'(station_addr), 64'd0);
        rd(STAT_OFS, s);            check(s == 0, "R1 ping status", 64'(s), 64'd0);
        rd(10'h200 + STAT_OFS, s);  check(s == 0, "R1 pong status", 64'(s), 64'd0);
        rd(10'h200 + LEN_OFS, s);   check(s == 0, "R1 pong length", 64'(s), 64'd0);

        // R3 R4 R8: ping frame with interrupt enabled
        fill(0, 7, 8'h11);
        irq0 = irq_cnt;
        start(0, 7, 1'b1);
        wait_idle(0, 32'h1, "R3 ping busy clears");
        drain("R3 ping frame complete");
        check(irq_cnt == irq0 + 1, "R8 irq on completion", 64'(irq_cnt), 64'(irq0 + 1));

        // R5: pong frame under backpressure, interrupt disabled
        bp = 1'b1;
        fill(1, 9, 8'h42);
        irq0 = irq_cnt;
        start(1, 9, 1'b0);
        wait_idle(1, 32'h1, "R5 pong busy clears");
        drain("R5 backpressured frame complete");
        check(irq_cnt == irq0, "R8 no irq without enable", 64'(irq_cnt), 64'(irq0));

        // R6: ping then pong, then pong then ping
        fill(0, 5, 8'h70);
        fill(1, 3, 8'hC3);
        start(0, 5, 1'b0);
        start(1, 3, 1'b0);
        rd(10'h200 + STAT_OFS, s);
        check(s[0] == 1'b1, "R6 second buffer waits busy", 64'(s[0]), 64'd1);
        wait_idle(0, 32'h1, "R6 ping done");
        wait_idle(1, 32'h1, "R6 pong done");
        drain("R6 order ping-pong");
        fill(0, 6, 8'h05);
        fill(1, 4, 8'hE1);
        start(1, 4, 1'b0);
        start(0, 6, 1'b0);
        wait_idle(1, 32'h1, "R6 pong done");
        wait_idle(0, 32'h1, "R6 ping done");
        drain("R6 order pong-ping");
        bp = 1'b0;

        // R7: zero length completes at once
        irq0 = irq_cnt;
        wr(LEN_OFS, 32'd0);
        wr(STAT_OFS, 32'h9);
        wait_idle(0, 32'h1, "R7 zero length busy clears");
        repeat (4) @(negedge clk);
        check(irq_cnt == irq0 + 1, "R7 zero length irq", 64'(irq_cnt), 64'(irq0 + 1));

        // R9: station address load from pong
        fill(1, 6, 8'hA0);
        wr(10'h200 + STAT_OFS, 32'h3);
        wait_idle(1, 32'h3, "R9 busy and program clear");
        check(station_addr == {img[1][0], img[1][1], img[1][2], img[1][3], img[1][4], img[1][5]},
              "R9 station value", 64'(station_addr),
              64'({img[1][0], img[1][1], img[1][2], img[1][3], img[1][4], img[1][5]}));

        // R10: storage bit
        wr(STAT_OFS, 32'h8000_0000);
        repeat (5) @(negedge clk);
        rd(STAT_OFS, s);
        check(s == 32'h8000_0000, "R10 bit31 kept", 64'(s), 64'h8000_0000);
        check(!tx_valid, "R10 nothing started", 64'(tx_valid), 64'd0);
        wr(STAT_OFS, 32'h0);

        // R2: length register width and buffer select
        wr(LEN_OFS, 32'hABCD_1234);
        rd(LEN_OFS, s);
        check(s == 32'h0000_1234, "R2 length low 16 bits", 64'(s), 64'h1234);
        rd(10'h200 + LEN_OFS, s);
        check(s == 32'd4, "R2 pong length untouched", 64'(s), 64'd4);

        // R11: abort a stalled frame
        ready_lvl = 1'b0;
        fill(0, 40, 8'h33);
        start(0, 40, 1'b0);
        for (int k = 0; k < 20 && !tx_valid; k++) @(negedge clk);
        wr(STAT_OFS, 32'h0);
        #3;
        check(!tx_valid, "R11 valid drops after abort", 64'(tx_valid), 64'd0);
        rd(STAT_OFS, s);
        check(s[0] == 1'b0, "R11 busy reads 0", 64'(s[0]), 64'd0);
        expq.delete();
        ready_lvl = 1'b1;
        repeat (3) @(negedge clk);

        // R3: recovery frame after abort
        fill(1, 5, 8'h99);
        start(1, 5, 1'b1);
        wait_idle(1, 32'h1, "R3 frame after abort");
        drain("R3 frame after abort complete");

        summary();
        $finish;
    end
endmodule